// File: doc/BRIEF.md
# Keyed configuration index/data port

This block sits behind a two-byte I/O window and gives a host access to a banked configuration space. The window has an index port at offset 0 and a data port at offset 1. After reset the space is locked. The host opens it by writing a parameterised enter key twice in a row to the index port, and closes it by writing a leave key to the index port.

While the space is open, the host writes a register index to offset 0 and then reads or writes that register through offset 1. Some registers are global:
- a logical-device number, which selects a register bank;
- a read-only chip identification byte.

Each logical device has an activate bit at index 0x30, and the block keeps those bits. Indices above 0x30 are passed on as single-cycle read and write strobes to the register file of the selected device.

Bus read data is combinational: it is valid in the same cycle as the read.

Top module: `keyed_cfg_port`

## Requirements
- R1: Two back-to-back index-port (offset 0) writes of ENTER_KEY open the space. Data-port writes between them do not disturb the sequence. A single ENTER_KEY write never opens it.
- R2: While closed, an index-port write of any value other than ENTER_KEY restarts key matching. The next ENTER_KEY then counts as the first of the pair. So ENTER, other, ENTER leaves the space closed.
- R3: While open, an index-port write of LEAVE_KEY closes the space and does not change the stored index. Any other index-port write while open becomes the new index.
- R4: While closed:
  - reads of either port return 0xFF;
  - data-port writes change no register and raise no strobe;
  - the stored index is unchanged.
- R5: While open, a read of offset 0 returns the stored index. An access to offset 1 reaches the register the index selects.
- R6: Index 0x07 is the logical-device number. It is read/write and 8 bits wide, and its low LDN_W bits drive dev_sel_o.
- R7: Index 0x20 reads as CHIP_ID. Writes to it have no effect.
- R8: Index 0x30 holds, in bit 0, the activate bit of the selected device, and act_o[n] shows device n's bit. Bits 7:1 read 0. If the device number is NUM_LDEV or more, index 0x30 reads 0x00 and writes are ignored.
- R9: For an index above 0x30 and a device number below NUM_LDEV, an open data-port write pulses dev_wr_o for that cycle, with dev_idx_o set to the index and dev_wdata_o to the byte. An open data-port read pulses dev_rd_o and returns dev_rdata_i.
- R10: Indices below 0x30 other than 0x07 and 0x20 read 0x00 and ignore writes. Indices above 0x30 read 0x00 and raise no strobe when the device number is invalid.
- R11: Asserting rst_ni low does all of the following:
  - closes the space;
  - clears the index and the device number to 0;
  - clears every activate bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | 1 | Window offset: 0 index port, 1 data port |
| bus_wdata_i | input | 8 | Bus write byte |
| bus_rdata_o | output | 8 | Bus read byte (combinational) |
| dev_sel_o | output | LDN_W | Selected logical device |
| dev_idx_o | output | 8 | Register index toward device files |
| dev_wdata_o | output | 8 | Write byte toward device files |
| dev_wr_o | output | 1 | Device register write strobe |
| dev_rd_o | output | 1 | Device register read strobe |
| dev_rdata_i | input | 8 | Read byte from the selected device file |
| act_o | output | NUM_LDEV | Activate bit of every logical device |

## Verification
The bench builds the block with the alternate key pair 0x88/0xBB, CHIP_ID 0x5C and NUM_LDEV 10. Because the keys are not the defaults, the bench can show that writing the default enter value twice leaves the space closed. With ten devices the number field is four bits wide, so device numbers 10 to 15 fit in dev_sel_o but are out of range, which exercises the suppression of strobes and activate writes. A behavioural model of the lock state, index, device number and activate bits is compared against the outputs on every clock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {KEY_LOCKED, KEY_HALF, KEY_OPEN} key_state_e;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_CHIP_ID = 8'h20;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] RD_LOCKED   = 8'hFF;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] ENTER_KEY = 8'h87,
  parameter logic [7:0] LEAVE_KEY = 8'hAA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic [7:0] key_data_i,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr_i) begin
      unique case (state_q)
        KEY_LOCKED: if (key_data_i == ENTER_KEY) state_d = KEY_HALF;
        KEY_HALF:   state_d = (key_data_i == ENTER_KEY) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   if (key_data_i == LEAVE_KEY) state_d = KEY_LOCKED;
        default:    state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == KEY_OPEN);

  AST_NO_DIRECT_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == KEY_LOCKED |=> state_q != KEY_OPEN); // R1
  AST_BREAK_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == KEY_HALF && key_wr_i && key_data_i != ENTER_KEY |=> state_q == KEY_LOCKED); // R2
  AST_LEAVE_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == KEY_OPEN && key_wr_i && key_data_i == LEAVE_KEY |=> state_q == KEY_LOCKED); // R3
endmodule

// File: rtl/cfg_ldev_bank.sv
module cfg_ldev_bank #(
  parameter int NUM_LDEV = 12,
  parameter int LDN_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ldn_we_i,
  input  logic                act_we_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          ldn_o,
  output logic                ldn_ok_o,
  output logic                act_sel_o,
  output logic [NUM_LDEV-1:0] act_o
);
  localparam logic [7:0] NUM_LDEV_B = 8'(NUM_LDEV);

  logic [7:0]          ldn_q;
  logic [NUM_LDEV-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ldn_q <= '0;
    else if (ldn_we_i) ldn_q <= wdata_i;
  end

  assign ldn_ok_o = (ldn_q < NUM_LDEV_B);

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q[g] <= 1'b0;
      else if (act_we_i && ldn_ok_o && ldn_q == 8'(g)) act_q[g] <= wdata_i[0];
    end
  end

  assign act_sel_o = ldn_ok_o ? act_q[ldn_q[LDN_W-1:0]] : 1'b0;
  assign ldn_o     = ldn_q;
  assign act_o     = act_q;

  AST_LDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldn_we_i |=> $stable(ldn_q)); // R6
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_we_i |=> $stable(act_q)); // R8
  AST_ACT_BAD_LDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_we_i && !ldn_ok_o |=> $stable(act_q)); // R8
  AST_ACT_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_we_i |=> $countones(act_q ^ $past(act_q)) <= 1); // R8
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] ENTER_KEY = 8'h87,
  parameter logic [7:0] LEAVE_KEY = 8'hAA,
  parameter logic [7:0] CHIP_ID   = 8'hA5,
  parameter int         NUM_LDEV  = 12,
  localparam int        LDN_W     = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic                bus_addr_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  output logic [LDN_W-1:0]    dev_sel_o,
  output logic [7:0]          dev_idx_o,
  output logic [7:0]          dev_wdata_o,
  output logic                dev_wr_o,
  output logic                dev_rd_o,
  input  logic [7:0]          dev_rdata_i,
  output logic [NUM_LDEV-1:0] act_o
);
  logic       key_open;
  logic       idx_port_wr, data_wr, fwd_ok;
  logic [7:0] idx_q, ldn;
  logic       ldn_ok, act_sel;

  assign idx_port_wr = bus_wr_i && !bus_addr_i;
  assign data_wr     = bus_wr_i && bus_addr_i && key_open;

  cfg_key_fsm #(.ENTER_KEY(ENTER_KEY), .LEAVE_KEY(LEAVE_KEY)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (idx_port_wr),
    .key_data_i (bus_wdata_i),
    .open_o     (key_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_port_wr && key_open && bus_wdata_i != LEAVE_KEY) idx_q <= bus_wdata_i;
  end

  cfg_ldev_bank #(.NUM_LDEV(NUM_LDEV), .LDN_W(LDN_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ldn_we_i  (data_wr && idx_q == IDX_LDN),
    .act_we_i  (data_wr && idx_q == IDX_ACT),
    .wdata_i   (bus_wdata_i),
    .ldn_o     (ldn),
    .ldn_ok_o  (ldn_ok),
    .act_sel_o (act_sel),
    .act_o     (act_o)
  );

  assign fwd_ok      = key_open && ldn_ok && (idx_q > IDX_ACT);
  assign dev_wr_o    = fwd_ok && bus_wr_i && bus_addr_i;
  assign dev_rd_o    = fwd_ok && bus_rd_i && bus_addr_i;
  assign dev_sel_o   = ldn[LDN_W-1:0];
  assign dev_idx_o   = idx_q;
  assign dev_wdata_o = bus_wdata_i;

  always_comb begin
    bus_rdata_o = 8'h00;
    if (!key_open)                bus_rdata_o = RD_LOCKED;
    else if (!bus_addr_i)         bus_rdata_o = idx_q;
    else if (idx_q == IDX_LDN)     bus_rdata_o = ldn;
    else if (idx_q == IDX_CHIP_ID) bus_rdata_o = CHIP_ID;
    else if (idx_q == IDX_ACT)     bus_rdata_o = {7'b0, act_sel};
    else if (fwd_ok)              bus_rdata_o = dev_rdata_i;
  end

  AST_IDX_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_open |=> $stable(idx_q)); // R4
  AST_LEAVE_NOT_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_open && idx_port_wr && bus_wdata_i == LEAVE_KEY |=> $stable(idx_q) && !key_open); // R3
  AST_LOCKED_LDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_open |=> $stable(ldn) && $stable(act_o)); // R4
  AST_STROBE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_o || dev_rd_o) |-> key_open && ldn < 8'(NUM_LDEV)); // R9
endmodule

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ENT = 8'h88, LEV = 8'hBB, CID = 8'h5C;
  localparam int NLD = 10;

  logic clk = 0, rst_ni = 0;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, dev_idx, dev_wdata, dev_rdata;
  logic [3:0] dev_sel;
  logic dev_wr, dev_rd;
  logic [NLD-1:0] act;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_cfg_port #(.ENTER_KEY(ENT), .LEAVE_KEY(LEV), .CHIP_ID(CID), .NUM_LDEV(NLD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .dev_sel_o(dev_sel), .dev_idx_o(dev_idx),
    .dev_wdata_o(dev_wdata), .dev_wr_o(dev_wr), .dev_rd_o(dev_rd), .dev_rdata_i(dev_rdata),
    .act_o(act));

  // device file stand-in
  assign dev_rdata = {dev_sel, 4'h0} ^ dev_idx ^ 8'h3C;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit m_open, m_half;
  logic [7:0] m_idx, m_ldn;
  logic [NLD-1:0] m_act;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata(bit addr);
    if (!m_open) return 8'hFF;
    if (!addr) return m_idx;
    if (m_idx == 8'h07) return m_ldn;
    if (m_idx == 8'h20) return CID;
    if (m_idx == 8'h30) return (m_ldn < NLD) ? {7'b0, m_act[m_ldn[3:0]]} : 8'h00;
    if (m_idx > 8'h30 && m_ldn < NLD) return {m_ldn[3:0], 4'h0} ^ m_idx ^ 8'h3C;
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_open = 0; m_half = 0; m_idx = 0; m_ldn = 0; m_act = '0;
  endtask

  task automatic op(string tag, bit wr, bit rd, bit addr, logic [7:0] d);
    bit ew, er;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = d;
    #1;
    ew = wr && addr && m_open && m_idx > 8'h30 && m_ldn < NLD;
    er = rd && addr && m_open && m_idx > 8'h30 && m_ldn < NLD;
    chk({tag, " rdata"}, 32'(bus_rdata), 32'(exp_rdata(addr)));
    chk({tag, " dev_wr"}, 32'(dev_wr), 32'(ew));
    chk({tag, " dev_rd"}, 32'(dev_rd), 32'(er));
    if (ew) begin
      chk({tag, " dev_idx"}, 32'(dev_idx), 32'(m_idx));
      chk({tag, " dev_wdata"}, 32'(dev_wdata), 32'(d));
    end
    if (wr && !addr) begin
      if (!m_open) begin
        if (m_half && d == ENT) begin m_open = 1; m_half = 0; end
        else m_half = (!m_half && d == ENT);
      end else if (d == LEV) m_open = 0;
      else m_idx = d;
    end else if (wr && addr && m_open) begin
      if (m_idx == 8'h07) m_ldn = d;
      else if (m_idx == 8'h30 && m_ldn < NLD) m_act[m_ldn[3:0]] = d[0];
    end
    @(posedge clk); #1;
    chk({tag, " act_o"}, 32'(act), 32'(m_act));
    chk({tag, " dev_sel"}, 32'(dev_sel), 32'(m_ldn[3:0]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_ni = 0; model_reset();
    #1;
    chk("R11 reset rdata", 32'(bus_rdata), 32'hFF);
    chk("R11 reset act_o", 32'(act), 0);
    chk("R11 reset dev_sel", 32'(dev_sel), 0);
    @(negedge clk); rst_ni = 1;
  endtask

  task automatic wr_idx(string t, logic [7:0] d); op(t, 1, 0, 0, d); endtask
  task automatic wr_dat(string t, logic [7:0] d); op(t, 1, 0, 1, d); endtask
  task automatic rd_idx(string t); op(t, 0, 1, 0, 8'h00); endtask
  task automatic rd_dat(string t); op(t, 0, 1, 1, 8'h00); endtask

  initial begin
    do_reset();
    rd_idx("R11 locked after reset");
    // R4 locked accesses
    wr_dat("R4 locked data write", 8'h05);
    rd_dat("R4 locked data read");
    // R1 default key has no effect with alternate pair
    wr_idx("R1 default key 1", 8'h87);
    wr_idx("R1 default key 2", 8'h87);
    rd_idx("R1 still locked");
    // R2 broken sequence
    wr_idx("R2 enter", ENT);
    wr_idx("R2 breaker", 8'h12);
    wr_idx("R2 enter again", ENT);
    rd_dat("R2 still locked");
    wr_idx("R2 second enter opens", ENT);
    rd_idx("R5 index read after open");
    wr_idx("R3 leave", LEV);
    // R1 data write between keys does not disturb
    wr_idx("R1 enter", ENT);
    wr_dat("R1 data write mid-key", 8'h33);
    wr_idx("R1 enter opens", ENT);
    rd_idx("R1 open");
    // R7 chip id
    wr_idx("R5 set idx 20", 8'h20);
    rd_dat("R7 chip id");
    wr_dat("R7 write ro", 8'h00);
    rd_dat("R7 chip id kept");
    // R6 / R8
    wr_idx("R5 set idx 07", 8'h07);
    wr_dat("R6 ldn write", 8'h03);
    rd_dat("R6 ldn read");
    wr_idx("R5 set idx 30", 8'h30);
    wr_dat("R8 activate", 8'hFF);
    rd_dat("R8 act read");
    // R9 forwarding
    wr_idx("R5 set idx 45", 8'h45);
    wr_dat("R9 dev write", 8'h5A);
    rd_dat("R9 dev read");
    // R10 unimplemented
    wr_idx("R10 idx 2f", 8'h2F);
    wr_dat("R10 write ignored", 8'h77);
    rd_dat("R10 read zero");
    wr_idx("R10 idx 00", 8'h00);
    rd_dat("R10 idx 00 zero");
    // R8/R10 invalid device number
    wr_idx("R6 idx 07", 8'h07);
    wr_dat("R6 ldn 12", 8'h0C);
    rd_dat("R6 ldn 12 read");
    wr_idx("R8 idx 30", 8'h30);
    rd_dat("R8 invalid ldn act");
    wr_dat("R8 invalid ldn write", 8'h01);
    wr_idx("R10 idx 45", 8'h45);
    wr_dat("R10 no strobe", 8'h11);
    rd_dat("R10 invalid ldn fwd");
    wr_idx("R6 idx 07", 8'h07);
    wr_dat("R6 ldn 3", 8'h03);
    wr_idx("R8 idx 30", 8'h30);
    rd_dat("R8 act kept");
    wr_dat("R8 clear act", 8'hFE);
    wr_idx("R6 idx 07", 8'h07);
    wr_dat("R6 ldn 9", 8'h09);
    wr_idx("R8 idx 30", 8'h30);
    wr_dat("R8 act dev9", 8'h01);
    // R3 leave, R4 locked write ignored
    wr_idx("R6 idx 07", 8'h07);
    wr_idx("R3 leave", LEV);
    rd_idx("R4 locked idx read");
    wr_dat("R4 locked ldn write", 8'h02);
    wr_idx("R1 enter", ENT);
    wr_idx("R1 enter", ENT);
    rd_idx("R3 index kept across leave");
    rd_dat("R4 ldn unchanged");
    // three enters: third stored as index
    wr_idx("R3 leave", LEV);
    wr_idx("R1 e1", ENT);
    wr_idx("R1 e2", ENT);
    wr_idx("R3 e3 as index", ENT);
    rd_idx("R3 index is key value");
    // R11 reset mid-session
    do_reset();
    rd_idx("R11 locked");
    wr_idx("R11 e1", ENT);
    wr_idx("R11 e2", ENT);
    rd_idx("R11 idx zero");
    wr_idx("R11 idx 07", 8'h07);
    rd_dat("R11 ldn zero");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule